// File: doc/BRIEF.md
# Host Register Interface for a Character Display Controller

This block is the interface between a host processor's parallel bus and the internal logic of a character display controller. The host drives a register-select line, a read/write line, an enable strobe and a data bus. None of these is synchronous to the controller clock, so the block samples all of them through two-flop synchronisers. It acts on each access when it sees the falling edge of the synchronised enable strobe. The register-select and read/write levels pick one of four operations: instruction write, status read, data write and data read.

The block holds a write-only instruction register and a data register. A status read returns the live busy flag and address counter. A data write stores the byte and asks the RAM side to store it. A data read returns the data register and then asks the RAM side for the next byte, which reloads the data register when it arrives. A data-length bit, set through a function-set instruction, selects an 8-bit bus or a 4-bit bus. In 4-bit mode each byte travels as two nibbles on the upper four data lines, high nibble first. While the busy flag is high, instruction writes are dropped and reported with an error pulse.

Top module: `hostbus_regif`

## Requirements
- R1: With select=0 and read/write=0, the completed byte is loaded into the instruction register (`instr_code`). `instr_stb` pulses for exactly one cycle, and is high in the third clock cycle after the enable falls at the pins.
- R2: With select=0 and read/write=1, `bus_dout` is {busy flag in bit 7, address counter in bits 6..0}, taken live from `busy_in` and `addr_ctr_in`.
- R3: With select=1 and read/write=0, the completed byte is loaded into the data register. `wr_req` pulses for one cycle with `wr_data` equal to that byte.
- R4: With select=1 and read/write=1, `bus_dout` returns the data register. When the byte completes, `rd_req` pulses for one cycle, and a later `ram_rvalid` loads `ram_rdata` into the data register for the next read.
- R5: The instruction register can never be read back. A status read after any instruction write still returns the busy flag and the address counter.
- R6: An instruction whose bits 7..5 are 001 sets the data-length bit from its bit 4 (1 = 8-bit bus, 0 = 4-bit bus). The data-length bit resets to 1. The nibble phase clears at reset and whenever the data-length bit changes.
- R7: In 4-bit mode a byte is written as two enable pulses. The first carries the high nibble on `bus_din[7:4]` and the second carries the low nibble. `bus_din[3:0]` is ignored, and the operation (R1, R3) fires only after the second pulse.
- R8: In 4-bit mode a read presents the high nibble on `bus_dout[7:4]` during the first pulse and the low nibble during the second, with `bus_dout[3:0]` at 0. For a status read the busy flag therefore appears on bit 7 of the first nibble.
- R9: `bus_oe` is high only while the synchronised read/write and enable are both high. Outside that window `bus_dout` is 0.
- R10: An instruction write that completes while `busy_in` is high leaves the instruction register and the data-length bit unchanged, gives no `instr_stb`, and pulses `err_pulse` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rs | input | 1 | Register select from host (0 instruction/status, 1 data) |
| bus_rw | input | 1 | Read/write from host (1 read) |
| bus_en | input | 1 | Access enable strobe from host |
| bus_din | input | 8 | Data bus from host |
| bus_dout | output | 8 | Data bus to host |
| bus_oe | output | 1 | Data bus output enable |
| busy_in | input | 1 | Busy flag from the execution logic |
| addr_ctr_in | input | 7 | Address counter from the execution logic |
| ram_rdata | input | 8 | Byte returned by the RAM side after a fetch |
| ram_rvalid | input | 1 | `ram_rdata` is valid this cycle |
| instr_code | output | 8 | Instruction register contents |
| instr_stb | output | 1 | One-cycle pulse: new instruction accepted |
| wr_data | output | 8 | Data register contents, written to RAM on `wr_req` |
| wr_req | output | 1 | One-cycle pulse: store the data register into RAM |
| rd_req | output | 1 | One-cycle pulse: fetch the next RAM byte |
| err_pulse | output | 1 | One-cycle pulse: instruction dropped while busy |

## Verification
The pulses `instr_stb`, `wr_req`, `rd_req` and `err_pulse` are registered. They rise on the third clock edge after the enable falls at the pins: two synchroniser edges, then the action edge. The bench checks that cycle exactly once, by sampling at the falling clock edges around it. For every other access it waits six cycles after the enable falls and then compares counters of the pulses and the value latched with each pulse. Read data and `bus_oe` come out two edges after the enable rises. The bench samples them four cycles into the pulse, and reads `ram_rdata` into the data register one cycle after the `rd_req` it answers.

// File: rtl/hbr_pkg.sv
// Package: shared operation encoding and function-set decode constants
// for the host register interface. Assumes an 8-bit instruction format.
package hbr_pkg;

    // Operation selected by {register select, read/write}
    typedef enum logic [1:0] {
        OP_IWR  = 2'b00,
        OP_STAT = 2'b01,
        OP_DWR  = 2'b10,
        OP_DRD  = 2'b11
    } hbr_op_e;

    // Function-set instruction is tagged by its top three bits
    localparam int          FN_TAG_W = 3;
    localparam logic [2:0]  FN_TAG   = 3'b001;

endpackage

// File: rtl/hbr_sync.sv
// Module: two-flop synchroniser bank, one chain per bit.
// Assumes inputs are level signals that stay stable far longer than a
// clock period; no glitch filtering is done.
module hbr_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic s1_q;
            logic s2_q;
            // Two-stage capture of one asynchronous bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1_q <= 1'b0;
                    s2_q <= 1'b0;
                end else begin
                    s1_q <= async_in[gi];
                    s2_q <= s1_q;
                end
            end
            assign sync_out[gi] = s2_q;
        end
    endgenerate

endmodule

// File: rtl/hbr_nibble.sv
// Module: byte assembly for the 8-bit or 4-bit bus.
// In wide mode every access completes a byte. In narrow mode the first
// access stores the high nibble from the upper lines and the second
// completes the byte. Assumes acc_fall is a single-cycle pulse.
module hbr_nibble #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_fall,
    input  logic          wide,
    input  logic          dl_chg,
    input  logic [DW-1:0] din,
    output logic          phase,
    output logic          byte_done,
    output logic [DW-1:0] byte_val
);

    localparam int NW = DW / 2;

    logic [NW-1:0] hi_q;

    // Nibble phase toggle and high-nibble hold register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= 1'b0;
            hi_q  <= '0;
        end else if (dl_chg) begin
            phase <= 1'b0;
        end else if (acc_fall && !wide) begin
            phase <= ~phase;
            if (!phase) begin
                hi_q <= din[DW-1:NW];
            end
        end
    end

    // Byte completion and assembled value
    always_comb begin
        byte_done = acc_fall & (wide | phase);
        byte_val  = wide ? din : {hi_q, din[DW-1:NW]};
    end

endmodule

// File: rtl/hbr_regs.sv
// Module: instruction register, data register, data-length bit and the
// one-cycle request pulses. Acts once per completed byte. A RAM refill of
// the data register yields to a host data write in the same cycle.
module hbr_regs
    import hbr_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DL_POS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_done,
    input  hbr_op_e       op,
    input  logic [DW-1:0] byte_val,
    input  logic          busy,
    input  logic          ram_rvalid,
    input  logic [DW-1:0] ram_rdata,
    output logic [DW-1:0] ir_q,
    output logic [DW-1:0] dr_q,
    output logic          dl_q,
    output logic          dl_chg,
    output logic          stb_q,
    output logic          wr_q,
    output logic          rd_q,
    output logic          err_q
);

    logic accept_ir;
    logic is_fnset;

    // Decode of an accepted instruction and a data-length change
    always_comb begin
        accept_ir = byte_done && (op == OP_IWR) && !busy;
        is_fnset  = (byte_val[DW-1 -: FN_TAG_W] == FN_TAG);
        dl_chg    = accept_ir && is_fnset && (byte_val[DL_POS] != dl_q);
    end

    // Instruction register and data-length bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            dl_q <= 1'b1;
        end else if (accept_ir) begin
            ir_q <= byte_val;
            if (is_fnset) begin
                dl_q <= byte_val[DL_POS];
            end
        end
    end

    // Data register: host write first, then RAM refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else if (byte_done && op == OP_DWR) begin
            dr_q <= byte_val;
        end else if (ram_rvalid) begin
            dr_q <= ram_rdata;
        end
    end

    // One-cycle request and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            wr_q  <= 1'b0;
            rd_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            stb_q <= accept_ir;
            wr_q  <= byte_done && (op == OP_DWR);
            rd_q  <= byte_done && (op == OP_DRD);
            err_q <= byte_done && (op == OP_IWR) && busy;
        end
    end

endmodule

// File: rtl/hostbus_regif.sv
// Module: host register interface top. Synchronises the host bus,
// detects the enable falling edge, assembles bytes and drives the read
// bus. Assumes select and read/write are held stable while enable is
// high and for a few clocks after it falls.
module hostbus_regif
    import hbr_pkg::*;
#(
    parameter int AW     = 7,
    parameter int DL_POS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rs,
    input  logic          bus_rw,
    input  logic          bus_en,
    input  logic [AW:0]   bus_din,
    output logic [AW:0]   bus_dout,
    output logic          bus_oe,
    input  logic          busy_in,
    input  logic [AW-1:0] addr_ctr_in,
    input  logic [AW:0]   ram_rdata,
    input  logic          ram_rvalid,
    output logic [AW:0]   instr_code,
    output logic          instr_stb,
    output logic [AW:0]   wr_data,
    output logic          wr_req,
    output logic          rd_req,
    output logic          err_pulse
);

    localparam int DW = AW + 1;
    localparam int NW = DW / 2;
    localparam int SW = DW + 3;

    logic [SW-1:0] sync_q;
    logic          rs_s, rw_s, en_s, en_d;
    logic [DW-1:0] din_s;
    logic          acc_fall;
    hbr_op_e       op;
    logic          phase, byte_done, dl_q, dl_chg;
    logic [DW-1:0] byte_val, dr_q;
    logic [DW-1:0] rd_byte;

    hbr_sync #(.W(SW)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_rs, bus_rw, bus_en, bus_din}),
        .sync_out (sync_q)
    );

    assign {rs_s, rw_s, en_s, din_s} = sync_q;

    // Delayed enable for falling-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_d <= 1'b0;
        end else begin
            en_d <= en_s;
        end
    end

    // Access edge and operation decode
    always_comb begin
        acc_fall = en_d & ~en_s;
        op       = hbr_op_e'({rs_s, rw_s});
    end

    hbr_nibble #(.DW(DW)) u_nib (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_fall  (acc_fall),
        .wide      (dl_q),
        .dl_chg    (dl_chg),
        .din       (din_s),
        .phase     (phase),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    hbr_regs #(.DW(DW), .DL_POS(DL_POS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_done  (byte_done),
        .op         (op),
        .byte_val   (byte_val),
        .busy       (busy_in),
        .ram_rvalid (ram_rvalid),
        .ram_rdata  (ram_rdata),
        .ir_q       (instr_code),
        .dr_q       (dr_q),
        .dl_q       (dl_q),
        .dl_chg     (dl_chg),
        .stb_q      (instr_stb),
        .wr_q       (wr_req),
        .rd_q       (rd_req),
        .err_q      (err_pulse)
    );

    assign wr_data = dr_q;

    // Read bus: status or data register, full byte or current nibble
    always_comb begin
        rd_byte = rs_s ? dr_q : {busy_in, addr_ctr_in};
        bus_oe  = rw_s & en_s;
        if (!bus_oe) begin
            bus_dout = '0;
        end else if (dl_q) begin
            bus_dout = rd_byte;
        end else if (!phase) begin
            bus_dout = {rd_byte[DW-1:NW], {NW{1'b0}}};
        end else begin
            bus_dout = {rd_byte[NW-1:0], {NW{1'b0}}};
        end
    end

endmodule

// File: rtl/hbr_chk.sv
// Module: property checker for the host register interface, bound to
// the top. Relates host pins to the request pulses and registers.
module hbr_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_rw,
    input logic          bus_oe,
    input logic          instr_stb,
    input logic          wr_req,
    input logic          rd_req,
    input logic          err_pulse,
    input logic [DW-1:0] instr_code
);

    a_r9_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rw, 2) |-> !bus_oe);

    a_r1_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        instr_stb |=> !instr_stb);

    a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);

    a_r4_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    a_r10_err_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $stable(instr_code));

    a_r1_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({instr_stb, wr_req, rd_req, err_pulse}));

endmodule

bind hostbus_regif hbr_chk #(.DW(AW + 1)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rw     (bus_rw),
    .bus_oe     (bus_oe),
    .instr_stb  (instr_stb),
    .wr_req     (wr_req),
    .rd_req     (rd_req),
    .err_pulse  (err_pulse),
    .instr_code (instr_code)
);

// File: tb/hostbus_regif_tb.sv
module hostbus_regif_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rs = 1'b0, bus_rw = 1'b0, bus_en = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_oe;
    logic       busy_in = 1'b0;
    logic [6:0] addr_ctr_in = 7'h00;
    logic [7:0] ram_rdata = 8'h00;
    logic       ram_rvalid = 1'b0;
    logic [7:0] instr_code, wr_data;
    logic       instr_stb, wr_req, rd_req, err_pulse;

    int n_chk = 0, n_bad = 0;
    int n_stb = 0, n_wr = 0, n_rd = 0, n_err = 0, n_fetch = 0;
    logic [7:0] last_code = 8'h00, last_wr = 8'h00;
    bit   mode8 = 1'b1;
    logic [7:0] exp_dr = 8'h00;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    hostbus_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_rw(bus_rw),
        .bus_en(bus_en), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .busy_in(busy_in), .addr_ctr_in(addr_ctr_in),
        .ram_rdata(ram_rdata), .ram_rvalid(ram_rvalid),
        .instr_code(instr_code), .instr_stb(instr_stb), .wr_data(wr_data),
        .wr_req(wr_req), .rd_req(rd_req), .err_pulse(err_pulse)
    );

    function automatic logic [7:0] fetch_val(int k);
        return 8'(k * 29 + 7);
    endfunction

    // Pulse counters and RAM-side fetch model
    always @(negedge clk) begin
        if (instr_stb) begin n_stb++; last_code = instr_code; end
        if (wr_req)    begin n_wr++;  last_wr = wr_data; end
        if (err_pulse) n_err++;
        if (rd_req) begin
            n_rd++;
            ram_rvalid = 1'b1;
            ram_rdata  = fetch_val(n_fetch);
            n_fetch++;
        end else begin
            ram_rvalid = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // One enable pulse; returns the read bus and output enable seen mid-pulse
    task automatic pulse(input bit rs, input bit rw, input logic [7:0] d,
                         output logic [7:0] rd, output bit oe_seen);
        @(negedge clk);
        bus_rs = rs; bus_rw = rw; bus_din = d; bus_en = 1'b1;
        repeat (4) @(negedge clk);
        rd = bus_dout; oe_seen = bus_oe;
        bus_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr_byte(input bit rs, input logic [7:0] b);
        logic [7:0] r; bit oe;
        if (mode8) begin
            pulse(rs, 1'b0, b, r, oe);
            chk(oe == 1'b0 && r == 8'h00, "R9", {oe, r}, 0);
        end else begin
            pulse(rs, 1'b0, {b[7:4], 4'h5}, r, oe);
            pulse(rs, 1'b0, {b[3:0], 4'hA}, r, oe);
        end
    endtask

    task automatic rd_byte(input bit rs, output logic [7:0] b);
        logic [7:0] h, l; bit oe1, oe2;
        if (mode8) begin
            pulse(rs, 1'b1, 8'h00, b, oe1);
            chk(oe1, "R9", oe1, 1);
        end else begin
            pulse(rs, 1'b1, 8'h00, h, oe1);
            pulse(rs, 1'b1, 8'h00, l, oe2);
            chk(oe1 && oe2 && h[3:0] == 0 && l[3:0] == 0, "R8", {h, l}, 0);
            b = {h[7:4], l[7:4]};
        end
    endtask

    // Instruction sweep: every code, function-set codes kept in the current width
    task automatic sweep_instr(input int step);
        for (int c = 0; c < 256; c += step) begin
            logic [7:0] code = 8'(c);
            int s0 = n_stb;
            if (code[7:5] == 3'b001) code[4] = mode8;
            wr_byte(1'b0, code);
            chk(n_stb == s0 + 1 && last_code == code && instr_code == code,
                mode8 ? "R1" : "R7", instr_code, code);
        end
    endtask

    task automatic sweep_dwr(input int step);
        for (int c = 0; c < 256; c += step) begin
            int w0 = n_wr;
            wr_byte(1'b1, 8'(c));
            chk(n_wr == w0 + 1 && last_wr == 8'(c), mode8 ? "R3" : "R7", last_wr, c);
            exp_dr = 8'(c);
        end
    endtask

    task automatic sweep_stat(input int step);
        for (int c = 0; c < 256; c += step) begin
            logic [7:0] r;
            busy_in = c[7]; addr_ctr_in = 7'(c);
            rd_byte(1'b0, r);
            chk(r == 8'(c), mode8 ? "R2" : "R8", r, c);
        end
        busy_in = 1'b0;
    endtask

    task automatic run_drd(input int count);
        for (int i = 0; i < count; i++) begin
            logic [7:0] r;
            int r0 = n_rd;
            rd_byte(1'b1, r);
            chk(r == exp_dr, "R4", r, exp_dr);
            chk(n_rd == r0 + 1, "R4", n_rd, r0 + 1);
            exp_dr = fetch_val(n_fetch - 1);
        end
    endtask

    task automatic busy_drop();
        int s0 = n_stb, e0 = n_err;
        logic [7:0] keep = instr_code;
        logic [7:0] r;
        busy_in = 1'b1;
        wr_byte(1'b0, {3'b001, ~mode8, 4'h0});
        busy_in = 1'b0;
        chk(n_stb == s0 && n_err == e0 + 1 && instr_code == keep, "R10",
            instr_code, keep);
        addr_ctr_in = 7'h3C;
        rd_byte(1'b0, r);
        chk(r == 8'h3C, "R10", r, 8'h3C);
    endtask

    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        chk(bus_oe == 0 && bus_dout == 0 && instr_code == 0 && !instr_stb,
            "R9", {bus_oe, bus_dout}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: exact cycle of the instruction strobe
        begin
            bit s1, s2, s3, s4;
            @(negedge clk); bus_rs = 0; bus_rw = 0; bus_din = 8'h0C; bus_en = 1;
            repeat (4) @(negedge clk);
            bus_en = 1'b0;
            @(negedge clk); s1 = instr_stb;
            @(negedge clk); s2 = instr_stb;
            @(negedge clk); s3 = instr_stb;
            @(negedge clk); s4 = instr_stb;
            chk({s1, s2, s3, s4} == 4'b0010, "R1", {s1, s2, s3, s4}, 4'b0010);
            repeat (4) @(negedge clk);
        end

        // 8-bit mode
        sweep_instr(1);
        rd_byte(1'b0, r);
        chk(r == {1'b0, addr_ctr_in}, "R5", r, {1'b0, addr_ctr_in});
        sweep_stat(1);
        sweep_dwr(1);
        run_drd(8);
        busy_drop();

        // R6: switch to the 4-bit bus
        wr_byte(1'b0, 8'h2C);
        mode8 = 1'b0;
        addr_ctr_in = 7'h51; busy_in = 1'b1;
        rd_byte(1'b0, r);
        busy_in = 1'b0;
        chk(r == 8'hD1, "R6", r, 8'hD1);

        sweep_dwr(1);
        sweep_instr(7);
        sweep_stat(5);
        run_drd(8);
        busy_drop();

        // R6: back to the 8-bit bus
        wr_byte(1'b0, 8'h38);
        mode8 = 1'b1;
        addr_ctr_in = 7'h2A;
        rd_byte(1'b0, r);
        chk(r == 8'h2A, "R6", r, 8'h2A);
        sweep_dwr(17);
        run_drd(3);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            summary();
            $finish;
        end
    end

endmodule